// File: doc/BRIEF.md
# GPIO interrupt line selector

This block turns a wide set of asynchronous GPIO pins into a small number of interrupt outputs. Each output line has its own selector that can pick any one of the pins. The chosen pin goes through a trigger stage that can run in one of several modes. It can follow the pin's level, active high or active low. It can pulse on a rising edge or on a falling edge. It can also pulse on every transition.

Software sets the block up through a plain register port: a write strobe with address and data, and a read data bus that is decoded combinationally. There is a control word, with a global enable, a polarity bit per line and a single-edge bit per line. Six select words each carry the pin choice for two lines. A separate word carries a both-edge bit per line, and this bit overrides the single-edge and polarity bits of that line.

Every pin is first brought into the clock domain through a two-stage synchroniser. Each line's trigger output is then registered. When the configuration of a line changes, its edge history is reloaded from the new source in the same cycle, so reprogramming a line never raises a false edge.

Top module: `gpio_irq_sel`

## Requirements
- R1: After reset every interrupt output is low, and all mapped registers read back as zero.
- R2: Register map. Address 0 is control: bit 31 is the global enable, bits 23:12 are the single-edge bits for lines 11..0 and bits 11:0 are the polarity bits for lines 11..0. Addresses 1..6 are the select words. Address 7 is the both-edge word, bits 11:0. Unimplemented bits read as 0. Addresses 8..15 read as 0, and writes to them change no register.
- R3: While the global enable is clear, every interrupt output is low, whatever the pins do. Outputs are low from the clock edge after the enable is cleared.
- R4: Select word at address X (1..6) sets line 2X-2 with bits 7:0 and line 2X-1 with bits 23:16. A select value from 0 to 81 picks that pin, and several lines may pick the same pin.
- R5: A select value of 82 or higher makes the line's source a constant 0.
- R6: In level mode (single-edge bit 0, both-edge bit 0), the output is the source value, inverted when the polarity bit is 1. It follows the pin with a latency of three clock edges.
- R7: In single-edge mode with polarity 0, each rising edge of the source gives a one-clock pulse on the third clock edge after the pin changes. Falling edges give nothing.
- R8: In single-edge mode with polarity 1, each falling edge gives a one-clock pulse with the same timing as R7. Rising edges give nothing.
- R9: With the line's both-edge bit set, every source transition gives a one-clock pulse, whatever the line's single-edge and polarity bits are.
- R10: A change to a line's select, polarity, single-edge or both-edge setting produces no edge pulse on that line, even when the new source differs from the old one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_in | input | 82 | Asynchronous GPIO pins |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| irq_out | output | 12 | Interrupt outputs, one per line |

## Verification
On every cycle, the assertions check four things:
- a cleared global enable forces the outputs low on the next edge;
- a single-edge line never pulses two cycles in a row;
- a level-high line tracks its source one edge later;
- a configuration change blocks any edge pulse, and an out-of-range select yields a zero source.

Other properties can only be shown by the bench's scenarios. These are:
- the exact three-edge latency from pin to output;
- the correct pairing of each select field with its line;
- the override of the polarity and single-edge bits by the both-edge bit;
- the readback masks.

The bench sweeps every line through all six mode combinations, each on its own pin.

// File: rtl/gis_pkg.sv
package gis_pkg;

  // Register layout
  localparam int CTRL_ADDR        = 0;
  localparam int SEL_BASE_ADDR    = 1;
  localparam int POL_LSB          = 0;
  localparam int SINGLE_LSB       = 12;
  localparam int ENABLE_BIT       = 31;
  localparam int SEL_FIELD_STRIDE = 16;

  typedef enum logic [2:0] {
    TRIG_LVL_HI,
    TRIG_LVL_LO,
    TRIG_RISE,
    TRIG_FALL,
    TRIG_ANY
  } trig_e;

  // Both-edge wins, then single-edge, then level
  function automatic trig_e decode_trig(input logic single, input logic pol, input logic both);
    if (both)   return TRIG_ANY;
    if (single) return pol ? TRIG_FALL : TRIG_RISE;
    return pol ? TRIG_LVL_LO : TRIG_LVL_HI;
  endfunction

  function automatic logic trig_hit(input trig_e mode, input logic prev, input logic cur);
    case (mode)
      TRIG_LVL_HI: return cur;
      TRIG_LVL_LO: return !cur;
      TRIG_RISE:   return cur && !prev;
      TRIG_FALL:   return !cur && prev;
      default:     return cur ^ prev;
    endcase
  endfunction

  function automatic logic is_edge_mode(input trig_e mode);
    return (mode == TRIG_RISE) || (mode == TRIG_FALL) || (mode == TRIG_ANY);
  endfunction

  // Address of the select word holding a given line
  function automatic int sel_reg_addr(input int line);
    return SEL_BASE_ADDR + line / 2;
  endfunction

  // Bit offset of a line's select field inside its word
  function automatic int sel_field_lsb(input int line);
    return (line % 2) * SEL_FIELD_STRIDE;
  endfunction

endpackage

// File: rtl/gis_regfile.sv
module gis_regfile #(
  parameter int NUM_LINES = 12,
  parameter int SEL_W     = 8,
  parameter int ADDR_W    = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [31:0]                     wdata,
  output logic [31:0]                     rdata,
  output logic                            en_o,
  output logic [NUM_LINES-1:0]            pol_o,
  output logic [NUM_LINES-1:0]            single_o,
  output logic [NUM_LINES-1:0]            both_o,
  output logic [NUM_LINES-1:0][SEL_W-1:0] sel_o
);
  import gis_pkg::*;

  localparam int NUM_SEL_REGS = (NUM_LINES + 1) / 2;
  localparam int BOTH_ADDR    = SEL_BASE_ADDR + NUM_SEL_REGS;

  logic                            en_q;
  logic [NUM_LINES-1:0]            pol_q;
  logic [NUM_LINES-1:0]            single_q;
  logic [NUM_LINES-1:0]            both_q;
  logic [NUM_LINES-1:0][SEL_W-1:0] sel_q;
  logic                            unmapped;
  logic                            unused_wdata;

  assign unmapped     = int'(addr) > BOTH_ADDR;
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      pol_q    <= '0;
      single_q <= '0;
      both_q   <= '0;
      sel_q    <= '0;
    end else if (wr_en) begin
      if (addr == ADDR_W'(CTRL_ADDR)) begin
        en_q     <= wdata[ENABLE_BIT];
        pol_q    <= wdata[POL_LSB +: NUM_LINES];
        single_q <= wdata[SINGLE_LSB +: NUM_LINES];
      end
      if (addr == ADDR_W'(BOTH_ADDR)) begin
        both_q <= wdata[NUM_LINES-1:0];
      end
      for (int i = 0; i < NUM_LINES; i++) begin
        if (addr == ADDR_W'(sel_reg_addr(i))) begin
          sel_q[i] <= wdata[sel_field_lsb(i) +: SEL_W];
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(CTRL_ADDR)) begin
      rdata[ENABLE_BIT]               = en_q;
      rdata[POL_LSB +: NUM_LINES]     = pol_q;
      rdata[SINGLE_LSB +: NUM_LINES]  = single_q;
    end
    if (addr == ADDR_W'(BOTH_ADDR)) begin
      rdata[NUM_LINES-1:0] = both_q;
    end
    for (int i = 0; i < NUM_LINES; i++) begin
      if (addr == ADDR_W'(sel_reg_addr(i))) begin
        rdata[sel_field_lsb(i) +: SEL_W] = sel_q[i];
      end
    end
  end

  assign en_o     = en_q;
  assign pol_o    = pol_q;
  assign single_o = single_q;
  assign both_o   = both_q;
  assign sel_o    = sel_q;

  AST_UNMAPPED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && unmapped) |=> $stable({en_q, pol_q, single_q, both_q, sel_q})); // R2

endmodule

// File: rtl/gis_pin_sync.sv
module gis_pin_sync #(
  parameter int WIDTH  = 82,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/gis_pin_mux.sv
module gis_pin_mux #(
  parameter int NUM_PINS = 82,
  parameter int SEL_W    = 8
) (
  input  logic [NUM_PINS-1:0] pins,
  input  logic [SEL_W-1:0]    sel,
  output logic                src
);
  logic sel_valid;

  assign sel_valid = int'(sel) < NUM_PINS;

  // One-hot compare over the pins; no match leaves the source at 0
  always_comb begin
    src = 1'b0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (sel == SEL_W'(p)) src = pins[p];
    end
  end

  always_comb begin
    AST_OOR_SEL_ZERO: assert (sel_valid || !src); // R5
  end

endmodule

// File: rtl/gis_line_detect.sv
module gis_line_detect #(
  parameter int SEL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src,
  input  logic [SEL_W-1:0] sel,
  input  logic             pol,
  input  logic             single,
  input  logic             both,
  input  logic             en,
  output logic             irq
);
  import gis_pkg::*;

  localparam int CFG_W = SEL_W + 3;

  logic [CFG_W-1:0] cfg;
  logic [CFG_W-1:0] cfg_q;
  logic             prev_q;
  logic             cfg_changed;
  logic             hit;
  logic             fire;
  trig_e            mode;

  assign cfg         = {sel, single, pol, both};
  assign cfg_changed = (cfg != cfg_q);
  assign mode        = decode_trig(single, pol, both);
  assign hit         = trig_hit(mode, prev_q, src);
  // Edge modes are blanked in the cycle the configuration moves
  assign fire        = hit && !(cfg_changed && is_edge_mode(mode));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      prev_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      cfg_q  <= cfg;
      prev_q <= src;
      irq    <= en && fire;
    end
  end

  AST_NO_PULSE_ON_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_changed && is_edge_mode(mode)) |=> !irq); // R10

  AST_SINGLE_EDGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && (mode == TRIG_RISE || mode == TRIG_FALL)) |=> !irq); // R7

  AST_LEVEL_TRACKS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == TRIG_LVL_HI) |=> (irq == $past(src))); // R6

endmodule

// File: rtl/gpio_irq_sel.sv
module gpio_irq_sel #(
  parameter int NUM_PINS    = 82,
  parameter int NUM_LINES   = 12,
  parameter int SEL_W       = 8,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PINS-1:0]  gpio_in,
  input  logic                 reg_wr_en,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic [NUM_LINES-1:0] irq_out
);
  logic                            ctl_en;
  logic [NUM_LINES-1:0]            ctl_pol;
  logic [NUM_LINES-1:0]            ctl_single;
  logic [NUM_LINES-1:0]            ctl_both;
  logic [NUM_LINES-1:0][SEL_W-1:0] ctl_sel;
  logic [NUM_PINS-1:0]             pins_sync;

  gis_regfile #(
    .NUM_LINES (NUM_LINES),
    .SEL_W     (SEL_W),
    .ADDR_W    (ADDR_W)
  ) i_regfile (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr_en),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .en_o     (ctl_en),
    .pol_o    (ctl_pol),
    .single_o (ctl_single),
    .both_o   (ctl_both),
    .sel_o    (ctl_sel)
  );

  gis_pin_sync #(
    .WIDTH  (NUM_PINS),
    .STAGES (SYNC_STAGES)
  ) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (gpio_in),
    .q     (pins_sync)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic src;

    gis_pin_mux #(
      .NUM_PINS (NUM_PINS),
      .SEL_W    (SEL_W)
    ) i_mux (
      .pins (pins_sync),
      .sel  (ctl_sel[g]),
      .src  (src)
    );

    gis_line_detect #(
      .SEL_W (SEL_W)
    ) i_det (
      .clk    (clk),
      .rst_n  (rst_n),
      .src    (src),
      .sel    (ctl_sel[g]),
      .pol    (ctl_pol[g]),
      .single (ctl_single[g]),
      .both   (ctl_both[g]),
      .en     (ctl_en),
      .irq    (irq_out[g])
    );
  end

  AST_GLOBAL_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> (irq_out == '0)); // R3

endmodule

// File: tb/test_gpio_irq_sel.sv
module test_gpio_irq_sel;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 82;
  localparam int NL = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pins = '0;
  logic          reg_wr_en = 1'b0;
  logic [3:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NL-1:0] irq_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_sel i_gpio_irq_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .gpio_in   (pins),
    .reg_wr_en (reg_wr_en),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_out   (irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_irq(input string req, input logic [NL-1:0] exp);
    check(req, {20'b0, irq_out}, {20'b0, exp});
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1 check(req, reg_rdata, exp);
  endtask

  task automatic set_pin(input int p, input logic v);
    @(negedge clk);
    pins[p] = v;
  endtask

  // Modes: 0 lvl-high, 1 lvl-low, 2 rise, 3 fall, 4 both(single=1,pol=1), 5 both(single=0,pol=0)
  task automatic cfg_line(input int line, input logic [7:0] p, input int m);
    logic pol, single, bo;
    logic [31:0] ctrl;
    pol    = (m == 1) || (m == 3) || (m == 4);
    single = (m == 2) || (m == 3) || (m == 4);
    bo     = (m >= 4);
    for (int r = 1; r <= 6; r++) begin
      logic [7:0] lo_s, hi_s;
      lo_s = (2*r-2 == line) ? p : 8'hFF;
      hi_s = (2*r-1 == line) ? p : 8'hFF;
      wr(4'(r), {8'h00, hi_s, 8'h00, lo_s});
    end
    ctrl = 32'h8000_0000;
    if (pol)    ctrl = ctrl | (32'd1 << line);
    if (single) ctrl = ctrl | (32'd1 << (12 + line));
    wr(4'd0, ctrl);
    wr(4'd7, bo ? (32'd1 << line) : 32'd0);
  endtask

  task automatic run_line(input int line, input int p, input int m);
    logic lvl, lo, rs, fl, bo;
    logic [NL-1:0] bit_l;
    string req;
    lvl = (m < 2); lo = (m == 1); rs = (m == 2); fl = (m == 3); bo = (m >= 4);
    bit_l = NL'(1) << line;
    req = lvl ? "R6" : rs ? "R7" : fl ? "R8" : "R9";
    cfg_line(line, 8'(p), m);
    repeat (4) @(posedge clk);
    #1 check_irq(req, (lvl && lo) ? bit_l : '0);
    for (int k = 0; k < 2; k++) begin
      logic nv, e1, e2;
      nv = (k == 0);
      set_pin(p, nv);
      repeat (3) @(posedge clk);
      e1 = lvl ? (nv ^ lo) : (bo || (rs && nv) || (fl && !nv));
      #1 check_irq(req, e1 ? bit_l : '0);
      @(posedge clk);
      e2 = lvl ? (nv ^ lo) : 1'b0;
      #1 check_irq(req, e2 ? bit_l : '0);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    #1 check_irq("R1", '0);
    for (int a = 0; a < 8; a++) rd_chk("R1", 4'(a), 32'd0);

    // R2: readback masks and unmapped addresses
    wr(4'd0, 32'hFFFF_FFFF);
    rd_chk("R2", 4'd0, 32'h80FF_FFFF);
    for (int a = 1; a <= 6; a++) begin
      wr(4'(a), 32'hFFFF_FFFF);
      rd_chk("R2", 4'(a), 32'h00FF_00FF);
    end
    wr(4'd7, 32'hFFFF_FFFF);
    rd_chk("R2", 4'd7, 32'h0000_0FFF);
    wr(4'd3, 32'h1234_5678);
    rd_chk("R2", 4'd3, 32'h0034_0078);
    wr(4'd9, 32'hFFFF_FFFF);
    rd_chk("R2", 4'd9, 32'd0);
    wr(4'd15, 32'h0);
    rd_chk("R2", 4'd0, 32'h80FF_FFFF);
    rd_chk("R2", 4'd7, 32'h0000_0FFF);
    for (int a = 0; a < 8; a++) wr(4'(a), 32'd0);

    // R4, R6..R9: every line in every mode on a spread of pins
    for (int line = 0; line < NL; line++) begin
      for (int m = 0; m < 6; m++) begin
        run_line(line, (line * 7 + m * 13) % NP, m);
      end
    end
    run_line(11, 81, 2);  // R4 top pin
    run_line(0, 81, 4);

    // R4, R9: all lines share pin 40 in both-edge mode
    for (int r = 1; r <= 6; r++) wr(4'(r), 32'h0028_0028);
    wr(4'd0, 32'h8000_0000);
    wr(4'd7, 32'h0000_0FFF);
    repeat (4) @(posedge clk);
    set_pin(40, 1'b1);
    repeat (3) @(posedge clk);
    #1 check_irq("R4", 12'hFFF);
    @(posedge clk);
    #1 check_irq("R9", 12'h000);
    set_pin(40, 1'b0);
    repeat (5) @(posedge clk);

    // R5: out-of-range selects give a constant 0 source
    pins = '1;
    cfg_line(7, 8'd82, 0);
    repeat (4) @(posedge clk);
    #1 check_irq("R5", '0);
    cfg_line(7, 8'd82, 1);
    repeat (4) @(posedge clk);
    #1 check_irq("R5", 12'h080);
    cfg_line(7, 8'd255, 1);
    repeat (4) @(posedge clk);
    #1 check_irq("R5", 12'h080);
    @(negedge clk);
    pins = '0;
    repeat (4) @(posedge clk);
    #1 check_irq("R5", 12'h080);

    // R3: global enable off
    cfg_line(2, 8'd30, 0);
    set_pin(30, 1'b1);
    repeat (4) @(posedge clk);
    #1 check_irq("R3", 12'h004);
    wr(4'd0, 32'h0000_0000);
    @(posedge clk);
    #1 check_irq("R3", '0);
    wr(4'd0, 32'h0000_4000);  // rise on line 2, enable clear
    repeat (3) @(posedge clk);
    set_pin(30, 1'b0);
    set_pin(30, 1'b1);
    for (int c = 0; c < 5; c++) begin
      @(posedge clk);
      #1 check_irq("R3", '0);
    end
    wr(4'd0, 32'h8000_4000);
    repeat (3) @(posedge clk);
    set_pin(30, 1'b0);
    set_pin(30, 1'b1);
    repeat (3) @(posedge clk);
    #1 check_irq("R3", 12'h004);
    set_pin(30, 1'b0);
    repeat (4) @(posedge clk);

    // R10: retargeting a line onto a high pin raises no pulse
    cfg_line(4, 8'd10, 2);
    set_pin(20, 1'b1);
    repeat (4) @(posedge clk);
    wr(4'd3, 32'h00FF_0014);
    #1 check_irq("R10", '0);
    for (int c = 0; c < 5; c++) begin
      @(posedge clk);
      #1 check_irq("R10", '0);
    end
    cfg_line(4, 8'd10, 4);
    repeat (4) @(posedge clk);
    wr(4'd3, 32'h00FF_0014);
    #1 check_irq("R10", '0);
    for (int c = 0; c < 5; c++) begin
      @(posedge clk);
      #1 check_irq("R10", '0);
    end
    set_pin(20, 1'b0);
    repeat (3) @(posedge clk);
    #1 check_irq("R10", 12'h010);
    @(posedge clk);
    #1 check_irq("R10", '0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule